// File: doc/BRIEF.md
# Configurable Trigger Output Combiner

This block turns a vector of trigger inputs into several independent trigger outputs. Sources such as a network-packet trigger, an energy detector, a gain-control completion flag, a software write strobe and four external pins each arrive already conditioned. Each input then passes through its own enable gate and an optional debounce filter before it reaches the combiner.

Each output has its own settings. A match-any mask selects the inputs that fire the output on their own. A match-all mask selects a group of inputs that fire the output only when all of them are high together. A delay setting holds the combined result back by a whole number of clock steps. A latch-mode bit keeps the output high once it has fired, until a clear strobe for that output arrives. The output pins are also the readback of each output's present state.

All configuration pins are plain static levels, and so are the clear strobes and the trigger pins. No stream interface exists, so there is no valid/ready handshake and no back-pressure. Every pin is sampled on each rising clock edge.

Top module: `trig_combiner`

## Requirements
- R1: An output goes high one clock edge after any enabled input that is set in its match-any mask (bit i of the output's mask slice selects input i) is high, when its delay is 0.
- R2: An output fires when every input set in its non-empty match-all mask is high at the same time. It does not fire when only some of those inputs are high.
- R3: A match-all mask of zero contributes nothing. With both masks zero, an output never fires.
- R4: An input whose enable bit is 0 reads as low for every output, both in match-any and in match-all terms.
- R5: A delay setting d (0 to 63) adds exactly d clock edges. The output changes d+1 edges after the combined condition changes.
- R6: With latch mode set, an output that has fired stays high after the inputs fall. It drops on the edge at which its clear strobe is high.
- R7: When a clear strobe and a new firing condition meet on the same edge, the output stays high.
- R8: With debounce set for an input, a new level is accepted only after 4 consecutive equal samples. This adds exactly 4 edges of latency on both rising and falling changes. A pulse lasting fewer than 4 samples is rejected.
- R9: Outputs are independent: latching, clearing or firing one output does not change any other output.
- R10: While reset is asserted and after it is released, all outputs read low until a firing condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 8 | Conditioned trigger sources |
| in_en | input | 8 | Per-input enable |
| deb_en | input | 8 | Per-input debounce select |
| any_mask | input | 48 | Match-any masks, 8 bits per output, output k at bits [8k+7:8k] |
| all_mask | input | 48 | Match-all masks, same layout as any_mask |
| dly_sel | input | 36 | Delay in clock steps, 6 bits per output, output k at bits [6k+5:6k] |
| latch_en | input | 6 | Per-output latch mode |
| clr | input | 6 | Per-output clear strobe |
| trig_out | output | 6 | Output trigger state, also the state readback |

## Verification
The hardest case to reach from the ports is a clear strobe that lands on the very edge where a latched output is being fired again. The bench holds the trigger input and the clear strobe high together for one edge, then drops the trigger while the clear stays high. This shows that the first edge keeps the output up and the second releases it. The 63-step delay and the debounce filter are reached in the same way. The bench first idles long enough to empty the delay line and the filter history, then counts edges exactly from the moment of stimulus.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // number of equal consecutive samples the debounce filter requires
  localparam int DEB_SAMPLES = 4;

  // combine one output's view of the enabled inputs
  function automatic logic group_hit(input logic [7:0] x,
                                     input logic [7:0] any_m,
                                     input logic [7:0] all_m);
    logic any_hit;
    logic all_hit;
    any_hit = |(x & any_m);
    all_hit = (|all_m) & (&(x | ~all_m));
    return any_hit | all_hit;
  endfunction
endpackage

// File: rtl/trig_in_cond.sv
module trig_in_cond
  import trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic en,
  input  logic deb_en,
  output logic dout
);
  localparam int HW = DEB_SAMPLES - 1;

  logic [HW-1:0] hist;
  logic          lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      lvl  <= 1'b0;
    end else begin
      hist <= {hist[HW-2:0], din};
      if (din && (&hist))
        lvl <= 1'b1;
      else if (!din && !(|hist))
        lvl <= 1'b0;
    end
  end

  assign dout = en & (deb_en ? lvl : din);

  // R8: the filtered level only rises after four high samples in a row
  p_deb_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl) |-> ($past(din, 1) && $past(din, 2) && $past(din, 3) && $past(din, 4)));
endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int MAX_DLY = 63,
  parameter int DLY_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [DLY_W-1:0] sel,
  output logic             dout
);
  localparam logic [DLY_W-1:0] TOP = DLY_W'(MAX_DLY);

  logic [MAX_DLY-1:0] pipe;
  logic [DLY_W-1:0]   eff;
  logic               primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '0;
      primed <= 1'b0;
    end else begin
      pipe   <= {pipe[MAX_DLY-2:0], din};
      primed <= 1'b1;
    end
  end

  assign eff  = (sel > TOP) ? TOP : sel;
  assign dout = (eff == '0) ? din : pipe[eff - DLY_W'(1)];

  // R5: a one-step setting returns the input seen one edge earlier
  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && sel == DLY_W'(1) && $past(sel) == DLY_W'(1)) |-> (dout == $past(din)));
endmodule

// File: rtl/trig_out_slice.sv
module trig_out_slice
  import trig_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int MAX_DLY = 63,
  parameter int DLY_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  x,
  input  logic [N_IN-1:0]  any_m,
  input  logic [N_IN-1:0]  all_m,
  input  logic [DLY_W-1:0] dly,
  input  logic             latch,
  input  logic             clear,
  output logic             q
);
  logic hit;
  logic dl;

  assign hit = group_hit(x, any_m, all_m);

  trig_delay_line #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (hit),
    .sel  (dly),
    .dout (dl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (latch)
      q <= dl | (q & ~clear);
    else
      q <= dl;
  end

  // R1: a delayed firing condition always shows on the output next edge
  p_fire_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dl |=> q);
  // R6: a latched output with no clear stays high
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && q && !clear) |=> q);
  // R6: outside latch mode the output falls with its condition
  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && !dl) |=> !q);
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner #(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 6,
  parameter int MAX_DLY = 63,
  parameter int DLY_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        trig_in,
  input  logic [N_IN-1:0]        in_en,
  input  logic [N_IN-1:0]        deb_en,
  input  logic [N_OUT*N_IN-1:0]  any_mask,
  input  logic [N_OUT*N_IN-1:0]  all_mask,
  input  logic [N_OUT*DLY_W-1:0] dly_sel,
  input  logic [N_OUT-1:0]       latch_en,
  input  logic [N_OUT-1:0]       clr,
  output logic [N_OUT-1:0]       trig_out
);
  logic [N_IN-1:0] cond;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    trig_in_cond u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trig_in[i]),
      .en    (in_en[i]),
      .deb_en(deb_en[i]),
      .dout  (cond[i])
    );
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    trig_out_slice #(.N_IN(N_IN), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_slice (
      .clk  (clk),
      .rst_n(rst_n),
      .x    (cond),
      .any_m(any_mask[k*N_IN +: N_IN]),
      .all_m(all_mask[k*N_IN +: N_IN]),
      .dly  (dly_sel[k*DLY_W +: DLY_W]),
      .latch(latch_en[k]),
      .clear(clr[k]),
      .q    (trig_out[k])
    );
  end

  // R4: with every input disabled, no output can fire beyond the delay window
  p_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en == '0 && dly_sel == '0 && latch_en == '0) |=> (trig_out == '0));
endmodule

// File: tb/trig_combiner_test.sv
`timescale 1ns/1ps
module trig_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [7:0]  in_en = '0;
  logic [7:0]  deb_en = '0;
  logic [47:0] any_mask = '0;
  logic [47:0] all_mask = '0;
  logic [35:0] dly_sel = '0;
  logic [5:0]  latch_en = '0;
  logic [5:0]  clr = '0;
  logic [5:0]  trig_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  trig_combiner uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .in_en(in_en), .deb_en(deb_en),
    .any_mask(any_mask), .all_mask(all_mask), .dly_sel(dly_sel),
    .latch_en(latch_en), .clr(clr), .trig_out(trig_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {trig_in, expected trig_out}; masks set below
  localparam logic [13:0] VEC [10] = '{
    {8'h00, 6'h00}, {8'h01, 6'h01}, {8'h02, 6'h00}, {8'h06, 6'h02},
    {8'h10, 6'h10}, {8'h30, 6'h14}, {8'h80, 6'h14}, {8'hFF, 6'h37},
    {8'hFE, 6'h16}, {8'h7F, 6'h17}
  };

  initial begin
    // out0: any in0; out1: all in1,in2; out2: any in7 or all in4,in5
    // out3: both masks empty (R3); out4: any in7..in4; out5: all inputs
    any_mask = {8'h00, 8'hF0, 8'h00, 8'h80, 8'h00, 8'h01};
    all_mask = {8'hFF, 8'h00, 8'h00, 8'h30, 8'h06, 8'h00};
    trig_in  = 8'hFF;
    in_en    = 8'hFF;
    tick(3);
    chk("R10 reset", trig_out, 6'h00);
    trig_in = 8'h00;
    rst_n = 1'b1;
    tick(2);
    chk("R10 after reset", trig_out, 6'h00);

    // R1 R2 R3 R9 table walk
    for (int i = 0; i < 10; i++) begin
      trig_in = VEC[i][13:6];
      tick(1);
      chk("R1 R2 R3 R9 vector", trig_out, VEC[i][5:0]);
    end

    // R4 disabled input
    in_en = 8'hFE;
    trig_in = 8'h01;
    tick(1);
    chk("R4 disabled any", trig_out, 6'h00);
    trig_in = 8'hFF;
    tick(1);
    chk("R4 disabled in all-group", trig_out, 6'h16);
    in_en = 8'hFF;
    trig_in = 8'h00;
    tick(70);

    // R5 delay of 5 and of 63
    dly_sel[5:0] = 6'd5;
    trig_in = 8'h01;
    tick(5);
    chk("R5 delay5 early", {5'b0, trig_out[0]}, 6'h00);
    tick(1);
    chk("R5 delay5 fire", {5'b0, trig_out[0]}, 6'h01);
    trig_in = 8'h00;
    dly_sel[5:0] = 6'd63;
    tick(70);
    trig_in = 8'h01;
    tick(63);
    chk("R5 delay63 early", {5'b0, trig_out[0]}, 6'h00);
    tick(1);
    chk("R5 delay63 fire", {5'b0, trig_out[0]}, 6'h01);
    trig_in = 8'h00;
    dly_sel = '0;
    tick(70);

    // R6 latch and clear, R9 neighbour unaffected
    latch_en = 6'h01;
    trig_in = 8'h11;
    tick(1);
    chk("R6 fire", trig_out, 6'h11);
    trig_in = 8'h00;
    tick(1);
    chk("R6 R9 held vs follow", trig_out, 6'h01);
    tick(4);
    chk("R6 still held", trig_out, 6'h01);
    clr = 6'h01;
    tick(1);
    clr = 6'h00;
    chk("R6 cleared", trig_out, 6'h00);

    // R7 clear meets new firing
    trig_in = 8'h01;
    clr = 6'h01;
    tick(1);
    chk("R7 trigger beats clear", trig_out, 6'h01);
    trig_in = 8'h00;
    tick(1);
    chk("R7 clear after", trig_out, 6'h00);
    clr = 6'h00;
    latch_en = 6'h00;
    tick(5);

    // R8 debounce: short pulse rejected
    deb_en = 8'h01;
    trig_in = 8'h01;
    tick(3);
    trig_in = 8'h00;
    begin
      logic seen;
      seen = 1'b0;
      for (int j = 0; j < 8; j++) begin
        tick(1);
        seen = seen | trig_out[0];
      end
      chk("R8 glitch rejected", {5'b0, seen}, 6'h00);
    end
    trig_in = 8'h01;
    tick(4);
    chk("R8 rise early", {5'b0, trig_out[0]}, 6'h00);
    tick(1);
    chk("R8 rise", {5'b0, trig_out[0]}, 6'h01);
    trig_in = 8'h00;
    tick(4);
    chk("R8 fall early", {5'b0, trig_out[0]}, 6'h01);
    tick(1);
    chk("R8 fall", {5'b0, trig_out[0]}, 6'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule